// File: doc/BRIEF.md
# Vector Saturating Left Shifter

This block takes a 128-bit vector and shifts every lane left by the same immediate amount. Each lane is clamped to the range of its output type instead of wrapping. Three flavours share one datapath: unsigned source to unsigned result, signed source to signed result, and signed source to unsigned result. Lanes are 8, 16, 32 or 64 bits wide, so a vector holds 16, 8, 4 or 2 lanes. A 7-bit immediate field gives both the lane width and the shift amount. A half-width mode works only on the low 64 bits of the vector.

An operation is presented with `in_valid`. One clock later the block shows the result, a flag for an illegal encoding, and a sticky saturation flag. The saturation flag rises when any active lane clamps and stays high until `qc_clear` is asserted. Control is a two-state machine. `ST_IDLE` moves to `ST_EMIT` when `in_valid` is high. `ST_EMIT` stays in `ST_EMIT` while `in_valid` remains high, and returns to `ST_IDLE` when it is low. `out_valid` is high exactly in `ST_EMIT`.

Top module: `vsatshl`

## Requirements
- R1: Lane width comes from the highest set bit of `imm_field[6:3]`: bit 3 alone gives 8, bit 4 gives 16, bit 5 gives 32 and bit 6 gives 64 bits. The shift amount is `imm_field` minus the lane width, which is always 0 to width-1.
- R2: Unsigned flavour (`u_bit`=1, `op_sel`=01110). A lane clamps when any bit pushed past its top is 1, and a clamped lane becomes all ones.
- R3: Signed flavour (`u_bit`=0, `op_sel`=01110). A lane clamps when any bit pushed out, or the new top bit, differs from the original sign. A clamped lane becomes 0111..1 for a positive source and 1000..0 for a negative one.
- R4: Signed-to-unsigned flavour (`u_bit`=1, `op_sel`=01100). A negative lane always becomes zero and counts as clamped, even with a shift of 0. A positive lane that loses a set bit becomes all ones.
- R5: With a shift of 0, the unsigned and signed flavours pass each lane through unchanged and never clamp.
- R6: With `q_bit`=0, result bits 127:64 are zero and lanes above bit 63 never set the saturation flag.
- R7: Three cases are reserved encodings: `q_bit`=0 with 64-bit lanes, `imm_field[6:3]`=0, and any select pair outside R2 to R4. A reserved operation sets `reserved_enc`, gives an all-zero result and does not set the saturation flag.
- R8: `qc_flag` is sticky. It is set when any active lane of a valid, non-reserved operation clamps, and no shift operation ever lowers it.
- R9: `qc_clear` lowers `qc_flag` on the next clock. A clamping operation in the same cycle still leaves the flag set.
- R10: Result, `reserved_enc` and `qc_flag` update on the clock edge that samples `in_valid`=1. `out_valid` is high for the cycle after each such edge, and the outputs hold while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| src | input | 128 | Source vector |
| op_sel | input | 5 | Operation select field |
| u_bit | input | 1 | Unsigned-select bit |
| q_bit | input | 1 | 1 = full 128-bit vector, 0 = low 64 bits only |
| imm_field | input | 7 | Lane width and shift immediate |
| qc_clear | input | 1 | Clears the saturation flag |
| out_valid | output | 1 | Result registers were loaded by the last edge |
| result | output | 128 | Shifted, clamped vector |
| reserved_enc | output | 1 | Last operation used a reserved encoding |
| qc_flag | output | 1 | Sticky saturation flag |

## Verification
The flavours are driven with lane values chosen to tell them apart. One example is 0x0123 shifted by 7, which fits as unsigned but overflows as signed. Another is 0xC0, which keeps its sign after one shift but loses it after two. Shift 0 with a negative source separates the signed-to-unsigned flavour from the other two. Mixed-lane and half-width patterns show that clamping is decided per lane and that upper lanes are ignored when `q_bit` is 0. Reserved encodings and sequences with and without `qc_clear` check that the flag sticks.

// File: rtl/vsatshl_pkg.sv
package vsatshl_pkg;
    typedef enum logic [1:0] {
        MD_UU = 2'd0,
        MD_SS = 2'd1,
        MD_SU = 2'd2
    } shl_mode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } shl_state_t;

    localparam logic [4:0] OPC_SAME = 5'b01110;
    localparam logic [4:0] OPC_S2U  = 5'b01100;
    localparam int         NSZ      = 4;
endpackage

// File: rtl/vsatshl_decode.sv
module vsatshl_decode
    import vsatshl_pkg::*;
(
    input  logic [6:0] imm_field,
    input  logic [4:0] op_sel,
    input  logic       u_bit,
    input  logic       q_bit,
    output logic [1:0] lsz,
    output logic [5:0] sh,
    output shl_mode_t  mode,
    output logic       rsv
);
    logic bad_op;

    always_comb begin
        lsz = 2'd0;
        sh  = 6'd0;
        if (imm_field[6]) begin
            lsz = 2'd3;
            sh  = imm_field[5:0];
        end else if (imm_field[5]) begin
            lsz = 2'd2;
            sh  = {1'b0, imm_field[4:0]};
        end else if (imm_field[4]) begin
            lsz = 2'd1;
            sh  = {2'b00, imm_field[3:0]};
        end else begin
            lsz = 2'd0;
            sh  = {3'b000, imm_field[2:0]};
        end
    end

    always_comb begin
        mode   = MD_UU;
        bad_op = 1'b0;
        if (op_sel == OPC_SAME) begin
            mode = u_bit ? MD_UU : MD_SS;
        end else if (op_sel == OPC_S2U && u_bit) begin
            mode = MD_SU;
        end else begin
            bad_op = 1'b1;
        end
    end

    assign rsv = bad_op || (imm_field[6:3] == 4'd0) || (!q_bit && lsz == 2'd3);
endmodule

// File: rtl/vsatshl_lane.sv
module vsatshl_lane
    import vsatshl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [5:0]   sh,
    input  shl_mode_t    mode,
    output logic [W-1:0] y,
    output logic         sat
);
    logic           sgn;
    logic [2*W-1:0] ext;
    logic [2*W-1:0] shd;
    logic [W-1:0]   hi;
    logic [W-1:0]   lo;
    logic [W:0]     top;

    assign sgn = x[W-1];
    assign ext = {{W{(mode != MD_UU) & sgn}}, x};
    assign shd = ext << sh;
    assign hi  = shd[2*W-1:W];
    assign lo  = shd[W-1:0];
    assign top = shd[2*W-1:W-1];

    always_comb begin
        sat = 1'b0;
        y   = lo;
        unique case (mode)
            MD_UU: begin
                sat = |hi;
                y   = sat ? {W{1'b1}} : lo;
            end
            MD_SS: begin
                sat = !(&top) && (|top);
                if (sat) y = sgn ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
            end
            MD_SU: begin
                sat = sgn | (|hi);
                if (sgn)      y = '0;
                else if (sat) y = {W{1'b1}};
            end
            default: begin
                sat = 1'b0;
                y   = lo;
            end
        endcase
    end
endmodule

// File: rtl/vsatshl.sv
module vsatshl
    import vsatshl_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] src,
    input  logic [4:0]       op_sel,
    input  logic             u_bit,
    input  logic             q_bit,
    input  logic [6:0]       imm_field,
    input  logic             qc_clear,
    output logic             out_valid,
    output logic [VEC_W-1:0] result,
    output logic             reserved_enc,
    output logic             qc_flag
);
    localparam int HALF = VEC_W / 2;

    logic [1:0]       lsz;
    logic [5:0]       sh;
    shl_mode_t        mode;
    logic             rsv;
    logic [VEC_W-1:0] res_by_sz [NSZ];
    logic             sat_by_sz [NSZ];
    logic [VEC_W-1:0] res_sel;
    logic             sat_sel;
    shl_state_t       state, state_nx;

    vsatshl_decode u_dec (
        .imm_field (imm_field),
        .op_sel    (op_sel),
        .u_bit     (u_bit),
        .q_bit     (q_bit),
        .lsz       (lsz),
        .sh        (sh),
        .mode      (mode),
        .rsv       (rsv)
    );

    for (genvar g = 0; g < NSZ; g++) begin : g_sz
        localparam int W  = 8 << g;
        localparam int NL = VEC_W / W;
        logic [VEC_W-1:0] res_w;
        logic [NL-1:0]    lane_sat;
        logic [NL-1:0]    lane_act;
        for (genvar l = 0; l < NL; l++) begin : g_ln
            localparam bit LOWER = (l * W) < HALF;
            vsatshl_lane #(.W(W)) u_lane (
                .x    (src[l*W +: W]),
                .sh   (sh),
                .mode (mode),
                .y    (res_w[l*W +: W]),
                .sat  (lane_sat[l])
            );
            assign lane_act[l] = q_bit | LOWER;
        end
        assign res_by_sz[g] = res_w;
        assign sat_by_sz[g] = |(lane_sat & lane_act);
    end

    always_comb begin
        res_sel = res_by_sz[lsz];
        sat_sel = sat_by_sz[lsz];
        if (!q_bit) res_sel[VEC_W-1:HALF] = '0;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid)  state_nx = ST_EMIT;
            ST_EMIT: if (!in_valid) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result       <= '0;
            reserved_enc <= 1'b0;
            qc_flag      <= 1'b0;
        end else begin
            qc_flag <= (qc_flag & ~qc_clear) | (in_valid & ~rsv & sat_sel);
            if (in_valid) begin
                result       <= rsv ? '0 : res_sel;
                reserved_enc <= rsv;
            end
        end
    end

    assign out_valid = (state == ST_EMIT);
endmodule

// File: rtl/vsatshl_chk.sv
module vsatshl_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             q_bit,
    input logic             qc_clear,
    input logic             out_valid,
    input logic [VEC_W-1:0] result,
    input logic             reserved_enc,
    input logic             qc_flag
);
    a_r8_qc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (qc_flag && !qc_clear) |=> qc_flag);

    a_r9_qc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (qc_clear && !in_valid) |=> !qc_flag);

    a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r10_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(reserved_enc)));

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !q_bit) |=> (result[VEC_W-1:VEC_W/2] == '0));

    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reserved_enc |-> (result == '0));
endmodule

bind vsatshl vsatshl_chk #(.VEC_W(VEC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .q_bit        (q_bit),
    .qc_clear     (qc_clear),
    .out_valid    (out_valid),
    .result       (result),
    .reserved_enc (reserved_enc),
    .qc_flag      (qc_flag)
);

// File: tb/vsatshl_tb.sv
module vsatshl_tb;
    localparam logic [4:0] OA = 5'b01110;
    localparam logic [4:0] OB = 5'b01100;
    localparam int NV = 19;

    // entry: {op[4:0], u, q, imm[6:0], src[127:0], exp[127:0], sat, rsv}
    localparam logic [271:0] TBL [NV] = '{
        {OA, 1'b1, 1'b1, 7'd9,   {16{8'h40}}, {16{8'h80}}, 1'b0, 1'b0},
        {OA, 1'b1, 1'b1, 7'd10,  {16{8'h40}}, {16{8'hff}}, 1'b1, 1'b0},
        {OA, 1'b0, 1'b1, 7'd9,   {16{8'h40}}, {16{8'h7f}}, 1'b1, 1'b0},
        {OA, 1'b0, 1'b1, 7'd9,   {16{8'hc0}}, {16{8'h80}}, 1'b0, 1'b0},
        {OA, 1'b0, 1'b1, 7'd10,  {16{8'hc0}}, {16{8'h80}}, 1'b1, 1'b0},
        {OB, 1'b1, 1'b1, 7'd8,   {16{8'h85}}, 128'h0,      1'b1, 1'b0},
        {OB, 1'b1, 1'b1, 7'd19,  {8{16'h0123}}, {8{16'h0918}}, 1'b0, 1'b0},
        {OB, 1'b1, 1'b1, 7'd23,  {8{16'h0123}}, {8{16'h9180}}, 1'b0, 1'b0},
        {OA, 1'b0, 1'b1, 7'd23,  {8{16'h0123}}, {8{16'h7fff}}, 1'b1, 1'b0},
        {OA, 1'b1, 1'b1, 7'd32,  {4{32'hdeadbeef}}, {4{32'hdeadbeef}}, 1'b0, 1'b0},
        {OA, 1'b0, 1'b1, 7'd32,  {4{32'h80000000}}, {4{32'h80000000}}, 1'b0, 1'b0},
        {OA, 1'b1, 1'b1, 7'd127, {64'h1, 64'h0}, {64'h8000000000000000, 64'h0}, 1'b0, 1'b0},
        {OA, 1'b1, 1'b1, 7'd68,  {64'h1000000000000000, 64'h1}, {64'hffffffffffffffff, 64'h10}, 1'b1, 1'b0},
        {OA, 1'b1, 1'b0, 7'd9,   {{8{8'hff}}, {8{8'h01}}}, {64'h0, {8{8'h02}}}, 1'b0, 1'b0},
        {OA, 1'b0, 1'b0, 7'd17,  {64'h0, {4{16'h4000}}}, {64'h0, {4{16'h7fff}}}, 1'b1, 1'b0},
        {OA, 1'b1, 1'b1, 7'd12,  {8{16'h0f10}}, {8{16'hf0ff}}, 1'b1, 1'b0},
        {OA, 1'b1, 1'b0, 7'd64,  {16{8'hff}}, 128'h0, 1'b0, 1'b1},
        {OB, 1'b0, 1'b1, 7'd9,   {16{8'hff}}, 128'h0, 1'b0, 1'b1},
        {OA, 1'b1, 1'b1, 7'd7,   {16{8'hff}}, 128'h0, 1'b0, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src = '0;
    logic [4:0]   op_sel = '0;
    logic         u_bit = 1'b0;
    logic         q_bit = 1'b0;
    logic [6:0]   imm_field = '0;
    logic         qc_clear = 1'b0;
    logic         out_valid;
    logic [127:0] result;
    logic         reserved_enc;
    logic         qc_flag;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    string tag [NV];

    always #5 clk = ~clk;

    vsatshl u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
        .op_sel(op_sel), .u_bit(u_bit), .q_bit(q_bit), .imm_field(imm_field),
        .qc_clear(qc_clear), .out_valid(out_valid), .result(result),
        .reserved_enc(reserved_enc), .qc_flag(qc_flag)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [4:0] op, input logic u, input logic q,
                         input logic [6:0] imm, input logic [127:0] s, input logic clr);
        @(negedge clk);
        op_sel = op; u_bit = u; q_bit = q; imm_field = imm; src = s;
        qc_clear = clr; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; qc_clear = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tag[0] = "R2";  tag[1] = "R2";  tag[2] = "R3";  tag[3] = "R3";
        tag[4] = "R3";  tag[5] = "R4";  tag[6] = "R4";  tag[7] = "R4";
        tag[8] = "R3";  tag[9] = "R5";  tag[10] = "R5"; tag[11] = "R1";
        tag[12] = "R1"; tag[13] = "R6"; tag[14] = "R6"; tag[15] = "R2";
        tag[16] = "R7"; tag[17] = "R7"; tag[18] = "R7";

        repeat (3) @(negedge clk);
        // reset state, R10
        chk("R10 reset out_valid", {127'h0, out_valid}, 128'h0);
        chk("R10 reset result", result, 128'h0);
        chk("R8 reset qc", {127'h0, qc_flag}, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [271:0] e;
            e = TBL[i];
            apply(e[271:267], e[266], e[265], e[264:258], e[257:130], 1'b1);
            chk({tag[i], " result"}, result, e[129:2]);
            chk({tag[i], " qc (R9 clear with op)"}, {127'h0, qc_flag}, {127'h0, e[1]});
            chk({tag[i], " reserved"}, {127'h0, reserved_enc}, {127'h0, e[0]});
            chk("R10 out_valid", {127'h0, out_valid}, 128'h1);
        end

        // R8: flag sticks through non-clamping and reserved operations
        apply(OA, 1'b1, 1'b1, 7'd10, {16{8'h40}}, 1'b0);
        chk("R8 set", {127'h0, qc_flag}, 128'h1);
        apply(OA, 1'b1, 1'b1, 7'd9, {16{8'h01}}, 1'b0);
        chk("R8 sticky", {127'h0, qc_flag}, 128'h1);
        chk("R2 no clamp", result, {16{8'h02}});
        apply(OA, 1'b1, 1'b1, 7'd7, {16{8'hff}}, 1'b0);
        chk("R7 qc kept", {127'h0, qc_flag}, 128'h1);

        // R10: idle cycle holds outputs and drops out_valid
        @(negedge clk);
        chk("R10 idle valid", {127'h0, out_valid}, 128'h0);
        chk("R10 hold result", result, 128'h0);

        // R9: clear alone
        @(negedge clk);
        qc_clear = 1'b1;
        @(negedge clk);
        qc_clear = 1'b0;
        chk("R9 clear", {127'h0, qc_flag}, 128'h0);

        // R6: upper lanes ignored for qc without clear
        apply(OA, 1'b1, 1'b0, 7'd12, {{8{8'hff}}, {8{8'h01}}}, 1'b0);
        chk("R6 qc low only", {127'h0, qc_flag}, 128'h0);
        chk("R6 result", result, {64'h0, {8{8'h10}}});

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule